// File: doc/BRIEF.md
# Misaligned Access Exception Unit

This unit sits beside the load/store path of a processor core. It examines every data access before it reaches memory. A halfword access must sit on a 2-byte boundary. A word access must sit on a 4-byte boundary, and an access that carries the lock flag always counts as a word access. An access that breaks its rule never reaches memory. Instead, the unit runs the hardware entry sequence for the address exception:

- It saves the live status bits into their backup copies.
- It clears the interrupt-enable and carry bits.
- It records the exact PC of the faulting instruction in a backup PC register.
- One cycle later, it steers instruction fetch to a fixed vector.

The unit also runs the return-from-exception command. The return restores the status bits from the backups. It also reloads fetch from the backup PC with the two low bits cleared. Execution therefore resumes at the word-aligned instruction pair that holds the faulting instruction.

An external interrupt request is granted only when interrupts are enabled and no address exception is taken in the same cycle. The status bits can be loaded from outside through a dedicated load strobe.

Top module: `misalign_exc_unit`

## Requirements
- R1: A halfword access (`acc_word_i`=0, `acc_lock_i`=0) faults when address bit 0 is 1, which covers low bits 01 and 11. Low bits 00 and 10 do not fault.
- R2: A word access (`acc_word_i`=1 or `acc_lock_i`=1) faults when the two low address bits are anything other than 00.
- R3: A faulting access raises neither `mem_rd_o` nor `mem_wr_o`. An aligned access raises `mem_rd_o` (load, `acc_we_i`=0) or `mem_wr_o` (store, `acc_we_i`=1) in the cycle after the request, with `mem_addr_o` equal to the request address.
- R4: `irq_grant_o` rises in the cycle after `ext_irq_i` is high, but only when IE=1, no entry is in progress and no fault is taken in that request cycle. When a fault and an interrupt arrive together, the exception wins and `irq_grant_o` stays low.
- R5: When the exception is taken, BSM, BIE and BC take the values that SM, IE and C held just before.
- R6: When the exception is taken, IE and C become 0 and SM keeps its value.
- R7: When the exception is taken, the backup PC takes the exact PC of the faulting instruction, including bit 1.
- R8: `exc_taken_o` pulses for one cycle, starting the cycle after the faulting request. In the cycle after that pulse, `vec_valid_o`=1 and `fetch_pc_o`=0x0000_0020. Requests, return commands and status loads presented while the pulse is high are ignored.
- R9: On `rte_i`, in the next cycle `ret_valid_o`=1 and `fetch_pc_o` equals the backup PC with bits 1:0 forced to 00. In that same cycle SM, IE and C take the values of BSM, BIE and BC. A fault presented in the same cycle wins over the return.
- R10: After synchronous reset, every output is 0, including the status bits, the backup bits and the backup PC.
- R11: When `psw_ld_i` is presented with no fault, no return and no entry in progress, SM, IE and C take `psw_sm_i`, `psw_ie_i` and `psw_c_i` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req_i | input | 1 | Data access request |
| acc_we_i | input | 1 | 1 = store, 0 = load |
| acc_word_i | input | 1 | 1 = word size, 0 = halfword size |
| acc_lock_i | input | 1 | Lock/unlock access; always treated as word size |
| acc_addr_i | input | AW | Effective data address |
| pc_i | input | AW | PC of the instruction issuing the access |
| ext_irq_i | input | 1 | External interrupt request |
| rte_i | input | 1 | Return-from-exception command |
| psw_ld_i | input | 1 | Load strobe for the status bits |
| psw_sm_i | input | 1 | SM value to load |
| psw_ie_i | input | 1 | IE value to load |
| psw_c_i | input | 1 | C value to load |
| mem_rd_o | output | 1 | Read strobe to memory |
| mem_wr_o | output | 1 | Write strobe to memory |
| mem_addr_o | output | AW | Address presented with the strobes |
| exc_taken_o | output | 1 | One-cycle pulse: address exception accepted |
| vec_valid_o | output | 1 | Fetch redirect to the exception vector |
| ret_valid_o | output | 1 | Fetch redirect for the return |
| fetch_pc_o | output | AW | Redirect target for fetch |
| irq_grant_o | output | 1 | External interrupt accepted |
| sm_o | output | 1 | Live SM bit |
| ie_o | output | 1 | Live IE bit |
| c_o | output | 1 | Live C bit |
| bsm_o | output | 1 | Backup SM |
| bie_o | output | 1 | Backup IE |
| bc_o | output | 1 | Backup C |
| bpc_o | output | AW | Backup PC |

## Verification
Each kind of internal fault shows up at the ports within one or two cycles:

- **Wrong alignment decode.** A strobe leaks in the cycle after a misaligned request, or `exc_taken_o` fires on an aligned one.
- **Corrupted backup state.** It is visible on the backup outputs in the cycle right after entry. It is visible again, one cycle after `rte_i`, as wrong restored status bits or a wrong `fetch_pc_o`.
- **Stuck sequencer state.** Either `vec_valid_o` fails to follow the pulse, or a request presented during the pulse is wrongly accepted. Either way it shows one cycle later as a second pulse, a strobe or an overwritten backup PC.

// File: rtl/mae_pkg.sv
package mae_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_VECT = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic sm;
    logic ie;
    logic c;
  } psw_bits_t;

endpackage

// File: rtl/mae_align_check.sv
module mae_align_check #(
  parameter int LOW_BITS = 2
) (
  input  logic                req_i,
  input  logic                word_i,
  input  logic                lock_i,
  input  logic [LOW_BITS-1:0] addr_lo_i,
  output logic                fault_o
);

  logic as_word;
  logic half_bad;
  logic word_bad;

  // Lock and unlock are always word sized.
  assign as_word  = word_i | lock_i;

  // A halfword only needs byte bit 0 clear.
  assign half_bad = addr_lo_i[0];

  // A word needs every low bit clear.
  assign word_bad = |addr_lo_i;

  assign fault_o  = req_i & (as_word ? word_bad : half_bad);

endmodule

// File: rtl/mae_status_regs.sv
module mae_status_regs
  import mae_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          entry_i,
  input  logic          ret_i,
  input  logic          ld_i,
  input  psw_bits_t     ld_psw_i,
  input  logic [AW-1:0] pc_i,
  output psw_bits_t     psw_o,
  output psw_bits_t     bpsw_o,
  output logic [AW-1:0] bpc_o
);

  psw_bits_t     psw_q;
  psw_bits_t     bpsw_q;
  logic [AW-1:0] bpc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      psw_q  <= '0;
      bpsw_q <= '0;
      bpc_q  <= '0;
    end else if (entry_i) begin
      // Back up, then clear IE and C; SM keeps its value.
      bpsw_q   <= psw_q;
      psw_q.ie <= 1'b0;
      psw_q.c  <= 1'b0;
      bpc_q    <= pc_i;
    end else if (ret_i) begin
      psw_q <= bpsw_q;
    end else if (ld_i) begin
      psw_q <= ld_psw_i;
    end
  end

  assign psw_o  = psw_q;
  assign bpsw_o = bpsw_q;
  assign bpc_o  = bpc_q;

  AST_BACKUP_COPY: assert property (@(posedge clk) disable iff (rst)
    entry_i |=> bpsw_q == $past(psw_q)); // R5

  AST_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    entry_i |=> (!psw_q.ie && !psw_q.c && psw_q.sm == $past(psw_q.sm))); // R6

  AST_BPC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    entry_i |=> bpc_q == $past(pc_i)); // R7

  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (rst)
    ret_i |=> psw_q == $past(bpsw_q)); // R9

endmodule

// File: rtl/mae_entry_seq.sv
module mae_entry_seq
  import mae_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [31:0] VEC_ADDR = 32'h0000_0020
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          fault_i,
  input  logic          rte_i,
  input  logic          ld_i,
  input  logic          irq_i,
  input  logic          ie_i,
  input  logic [AW-1:0] bpc_i,
  output logic          entry_o,
  output logic          ret_o,
  output logic          ld_ok_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          exc_taken_o,
  output logic          vec_valid_o,
  output logic          ret_valid_o,
  output logic [AW-1:0] fetch_pc_o,
  output logic          irq_grant_o
);

  localparam logic [AW-1:0] ALIGN_MASK = AW'(3);
  localparam logic [AW-1:0] VEC_PC     = AW'(VEC_ADDR);

  seq_state_e    state_q;
  seq_state_e    state_d;
  logic          busy;
  logic          pass_ok;
  logic          mem_rd_q;
  logic          mem_wr_q;
  logic [AW-1:0] mem_addr_q;
  logic          exc_q;
  logic          vec_q;
  logic          ret_q;
  logic [AW-1:0] fetch_q;
  logic          grant_q;

  assign busy    = (state_q == ST_VECT);
  assign entry_o = fault_i & ~busy;
  assign ret_o   = rte_i & ~busy & ~fault_i;
  assign ld_ok_o = ld_i & ~busy & ~fault_i & ~rte_i;
  assign pass_ok = req_i & ~busy & ~fault_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (entry_o) state_d = ST_VECT;
      ST_VECT: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      mem_rd_q   <= 1'b0;
      mem_wr_q   <= 1'b0;
      mem_addr_q <= '0;
      exc_q      <= 1'b0;
      vec_q      <= 1'b0;
      ret_q      <= 1'b0;
      fetch_q    <= '0;
      grant_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      mem_rd_q <= pass_ok & ~we_i;
      mem_wr_q <= pass_ok & we_i;
      if (pass_ok) mem_addr_q <= addr_i;
      exc_q    <= entry_o;
      vec_q    <= busy;
      ret_q    <= ret_o;
      if (busy)       fetch_q <= VEC_PC;
      else if (ret_o) fetch_q <= bpc_i & ~ALIGN_MASK;
      grant_q  <= irq_i & ie_i & ~busy & ~fault_i & ~rte_i;
    end
  end

  assign mem_rd_o    = mem_rd_q;
  assign mem_wr_o    = mem_wr_q;
  assign mem_addr_o  = mem_addr_q;
  assign exc_taken_o = exc_q;
  assign vec_valid_o = vec_q;
  assign ret_valid_o = ret_q;
  assign fetch_pc_o  = fetch_q;
  assign irq_grant_o = grant_q;

  AST_NO_STROBE_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
    exc_taken_o |-> (!mem_rd_o && !mem_wr_o)); // R3

  AST_IRQ_LOSES: assert property (@(posedge clk) disable iff (rst)
    exc_taken_o |-> !irq_grant_o); // R4

  AST_VECTOR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    exc_taken_o |=> (vec_valid_o && !exc_taken_o && fetch_pc_o == VEC_PC)); // R8

  AST_ONE_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exc_taken_o, vec_valid_o, ret_valid_o})); // R8

  AST_RET_WORD: assert property (@(posedge clk) disable iff (rst)
    ret_valid_o |-> fetch_pc_o[1:0] == 2'b00); // R9

endmodule

// File: rtl/misalign_exc_unit.sv
module misalign_exc_unit
  import mae_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          LOW_BITS = 2,
  parameter logic [31:0] VEC_ADDR = 32'h0000_0020
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_req_i,
  input  logic          acc_we_i,
  input  logic          acc_word_i,
  input  logic          acc_lock_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [AW-1:0] pc_i,
  input  logic          ext_irq_i,
  input  logic          rte_i,
  input  logic          psw_ld_i,
  input  logic          psw_sm_i,
  input  logic          psw_ie_i,
  input  logic          psw_c_i,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          exc_taken_o,
  output logic          vec_valid_o,
  output logic          ret_valid_o,
  output logic [AW-1:0] fetch_pc_o,
  output logic          irq_grant_o,
  output logic          sm_o,
  output logic          ie_o,
  output logic          c_o,
  output logic          bsm_o,
  output logic          bie_o,
  output logic          bc_o,
  output logic [AW-1:0] bpc_o
);

  logic          fault;
  logic          entry;
  logic          ret;
  logic          ld_ok;
  psw_bits_t     psw;
  psw_bits_t     bpsw;
  psw_bits_t     ld_psw;
  logic [AW-1:0] bpc;

  assign ld_psw = '{sm: psw_sm_i, ie: psw_ie_i, c: psw_c_i};

  mae_align_check #(
    .LOW_BITS (LOW_BITS)
  ) u_align (
    .req_i     (acc_req_i),
    .word_i    (acc_word_i),
    .lock_i    (acc_lock_i),
    .addr_lo_i (acc_addr_i[LOW_BITS-1:0]),
    .fault_o   (fault)
  );

  mae_entry_seq #(
    .AW       (AW),
    .VEC_ADDR (VEC_ADDR)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_i       (acc_req_i),
    .we_i        (acc_we_i),
    .addr_i      (acc_addr_i),
    .fault_i     (fault),
    .rte_i       (rte_i),
    .ld_i        (psw_ld_i),
    .irq_i       (ext_irq_i),
    .ie_i        (psw.ie),
    .bpc_i       (bpc),
    .entry_o     (entry),
    .ret_o       (ret),
    .ld_ok_o     (ld_ok),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_addr_o  (mem_addr_o),
    .exc_taken_o (exc_taken_o),
    .vec_valid_o (vec_valid_o),
    .ret_valid_o (ret_valid_o),
    .fetch_pc_o  (fetch_pc_o),
    .irq_grant_o (irq_grant_o)
  );

  mae_status_regs #(
    .AW (AW)
  ) u_status (
    .clk      (clk),
    .rst      (rst),
    .entry_i  (entry),
    .ret_i    (ret),
    .ld_i     (ld_ok),
    .ld_psw_i (ld_psw),
    .pc_i     (pc_i),
    .psw_o    (psw),
    .bpsw_o   (bpsw),
    .bpc_o    (bpc)
  );

  assign sm_o  = psw.sm;
  assign ie_o  = psw.ie;
  assign c_o   = psw.c;
  assign bsm_o = bpsw.sm;
  assign bie_o = bpsw.ie;
  assign bc_o  = bpsw.c;
  assign bpc_o = bpc;

endmodule

// File: tb/misalign_exc_unit_tb.sv
module misalign_exc_unit_tb;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_req_i = 1'b0;
  logic          acc_we_i = 1'b0;
  logic          acc_word_i = 1'b0;
  logic          acc_lock_i = 1'b0;
  logic [AW-1:0] acc_addr_i = '0;
  logic [AW-1:0] pc_i = '0;
  logic          ext_irq_i = 1'b0;
  logic          rte_i = 1'b0;
  logic          psw_ld_i = 1'b0;
  logic          psw_sm_i = 1'b0;
  logic          psw_ie_i = 1'b0;
  logic          psw_c_i = 1'b0;
  logic          mem_rd_o, mem_wr_o, exc_taken_o, vec_valid_o, ret_valid_o, irq_grant_o;
  logic [AW-1:0] mem_addr_o, fetch_pc_o, bpc_o;
  logic          sm_o, ie_o, c_o, bsm_o, bie_o, bc_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  misalign_exc_unit #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst),
    .acc_req_i(acc_req_i), .acc_we_i(acc_we_i), .acc_word_i(acc_word_i),
    .acc_lock_i(acc_lock_i), .acc_addr_i(acc_addr_i), .pc_i(pc_i),
    .ext_irq_i(ext_irq_i), .rte_i(rte_i), .psw_ld_i(psw_ld_i),
    .psw_sm_i(psw_sm_i), .psw_ie_i(psw_ie_i), .psw_c_i(psw_c_i),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
    .exc_taken_o(exc_taken_o), .vec_valid_o(vec_valid_o), .ret_valid_o(ret_valid_o),
    .fetch_pc_o(fetch_pc_o), .irq_grant_o(irq_grant_o),
    .sm_o(sm_o), .ie_o(ie_o), .c_o(c_o),
    .bsm_o(bsm_o), .bie_o(bie_o), .bc_o(bc_o), .bpc_o(bpc_o)
  );

  // Row fields: [5] word, [4] lock, [3] store, [2:1] low address bits, [0] fault expected
  localparam logic [5:0] VEC_TBL [12] = '{
    6'b0_0_0_00_0, 6'b0_0_0_01_1, 6'b0_0_0_10_0, 6'b0_0_0_11_1,
    6'b0_0_1_11_1, 6'b0_0_1_10_0, 6'b1_0_0_00_0, 6'b1_0_0_01_1,
    6'b1_0_0_10_1, 6'b1_0_1_11_1, 6'b0_1_0_10_1, 6'b0_1_1_00_0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    acc_req_i = 0; acc_we_i = 0; acc_word_i = 0; acc_lock_i = 0;
    ext_irq_i = 0; rte_i = 0; psw_ld_i = 0;
  endtask

  task automatic fault_then_return(input logic [31:0] pc, input logic [31:0] exp_pc);
    @(negedge clk);
    acc_req_i = 1; acc_word_i = 0; acc_addr_i = 32'h5003; pc_i = pc;
    @(negedge clk);
    chk("R7 bpc", bpc_o, pc);
    idle_inputs();
    @(negedge clk);
    rte_i = 1;
    @(negedge clk);
    chk("R9 return pc", fetch_pc_o, exp_pc);
    chk("R9 ret_valid", {31'd0, ret_valid_o}, 32'd1);
    idle_inputs();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 strobes/pulses", {26'd0, mem_rd_o, mem_wr_o, exc_taken_o, vec_valid_o, ret_valid_o, irq_grant_o}, 32'd0);
    chk("R10 status", {26'd0, sm_o, ie_o, c_o, bsm_o, bie_o, bc_o}, 32'd0);
    chk("R10 bpc", bpc_o, 32'd0);
    chk("R10 fetch", fetch_pc_o, 32'd0);

    // Table walk: R1, R2, R3
    for (int i = 0; i < 12; i++) begin
      logic [5:0] v;
      logic [31:0] a;
      v = VEC_TBL[i];
      a = 32'h1000 + (32'(i) << 4) + {30'd0, v[2:1]};
      acc_req_i = 1; acc_word_i = v[5]; acc_lock_i = v[4]; acc_we_i = v[3];
      acc_addr_i = a; pc_i = 32'h200 + 32'(i) * 2;
      @(negedge clk);
      chk((v[5] | v[4]) ? "R2 fault decode" : "R1 fault decode", {31'd0, exc_taken_o}, {31'd0, v[0]});
      chk("R3 read strobe", {31'd0, mem_rd_o}, {31'd0, !v[0] && !v[3]});
      chk("R3 write strobe", {31'd0, mem_wr_o}, {31'd0, !v[0] && v[3]});
      if (!v[0]) chk("R3 address", mem_addr_o, a);
      idle_inputs();
      @(negedge clk);
    end

    // R11 status load, then R4 interrupt grant
    psw_ld_i = 1; psw_sm_i = 1; psw_ie_i = 1; psw_c_i = 1;
    @(negedge clk);
    chk("R11 status load", {29'd0, sm_o, ie_o, c_o}, 32'd7);
    idle_inputs();
    ext_irq_i = 1;
    @(negedge clk);
    chk("R4 grant", {31'd0, irq_grant_o}, 32'd1);

    // Fault together with interrupt: R4, R5, R6, R7, R3
    acc_req_i = 1; acc_word_i = 1; acc_addr_i = 32'h3002; pc_i = 32'h6; ext_irq_i = 1;
    @(negedge clk);
    chk("R8 pulse", {31'd0, exc_taken_o}, 32'd1);
    chk("R4 exception wins", {31'd0, irq_grant_o}, 32'd0);
    chk("R3 no strobe", {30'd0, mem_rd_o, mem_wr_o}, 32'd0);
    chk("R5 backup", {29'd0, bsm_o, bie_o, bc_o}, 32'd7);
    chk("R6 cleared", {29'd0, sm_o, ie_o, c_o}, 32'd4);
    chk("R7 bpc", bpc_o, 32'h6);
    // Request during entry must be ignored (R8)
    acc_addr_i = 32'h3001; pc_i = 32'h100; rte_i = 1;
    @(negedge clk);
    chk("R8 vector valid", {31'd0, vec_valid_o}, 32'd1);
    chk("R8 vector pc", fetch_pc_o, 32'h20);
    chk("R8 single pulse", {31'd0, exc_taken_o}, 32'd0);
    chk("R8 ignored request", {30'd0, mem_rd_o, ret_valid_o}, 32'd0);
    chk("R8 bpc kept", bpc_o, 32'h6);
    idle_inputs();
    @(negedge clk);
    chk("R8 vector drops", {31'd0, vec_valid_o}, 32'd0);
    rte_i = 1;
    @(negedge clk);
    chk("R9 ret_valid", {31'd0, ret_valid_o}, 32'd1);
    chk("R9 return pc 6", fetch_pc_o, 32'h4);
    chk("R9 restore", {29'd0, sm_o, ie_o, c_o}, 32'd7);
    idle_inputs();

    fault_then_return(32'h4, 32'h4);
    fault_then_return(32'h10A, 32'h108);

    // Fault beats return in the same cycle (R9)
    @(negedge clk);
    acc_req_i = 1; acc_word_i = 1; acc_addr_i = 32'h7003; pc_i = 32'h40; rte_i = 1;
    @(negedge clk);
    chk("R9 fault over return", {30'd0, exc_taken_o, ret_valid_o}, 32'd2);
    idle_inputs();
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule